// File: doc/BRIEF.md
# Spread-Spectrum Mode Decoder and Triangle Offset Generator

This block turns three frequency-select pins and an active-low spread-enable pin into an operating mode for a clock generator, and produces a signed fractional-offset word that a downstream divider or PLL model applies to the processor clock. The select code is formed as {speed select, fsel[1], fsel[0]}. Two codes carry no spread: 000 sends every clock output to high impedance, and 100 is a test mode in which the processor output is the input clock divided by 2 and the bus output is the input divided by 6. The other six codes choose a 66.6 MHz processor clock (speed select low) or a 100 MHz processor clock (speed select high), with a 33.3 MHz bus clock in all of them. Their two low bits choose the spread shape and depth.

While spread is enabled, the offset follows a repeating triangle sweep. The sweep takes one step of 0.01% on each modulation-rate tick and reverses direction at each bound. In center spread the sweep runs evenly on both sides of nominal. In the two down-spread depths it runs between nominal and the negative depth. The rate tick comes from an internal divider of the reference clock with a parameterised period. Any change of select code or spread enable restarts the sweep at zero, so the offset never leaves the bounds of the new mode.

Top module: `ssc_mode_sweep`

## Requirements
- R1: Select code 000 gives hiz_flag=1, test_flag=0 and ofs_word=0, whatever the value of spread_n.
- R2: Select code 100 gives test_flag=1, hiz_flag=0 and ofs_word=0, whatever the value of spread_n. Every other code gives test_flag=0 and hiz_flag=0.
- R3: mode_code equals the select code {speed_sel, fsel} sampled at the previous rising clock edge. Bit 2 (speed) set means 100 MHz and clear means 66.6 MHz.
- R4: While spread_n is 1, ofs_word is 0 in every mode.
- R5: fsel=01 with spread_n=0 is center spread. ofs_word (signed, units of 0.01%) sweeps from -45 up to +45 and back, reaching both limits.
- R6: fsel=10 with spread_n=0 is deep down spread. ofs_word sweeps between -100 and 0 and reaches both limits.
- R7: fsel=11 with spread_n=0 is shallow down spread. ofs_word sweeps between -50 and 0 and reaches both limits.
- R8: During spread, ofs_word changes by exactly +1 or -1 on each rate tick and stays unchanged between ticks.
- R9: The sweep reverses at each limit. A value at the lower limit is followed by the limit plus 1, and a value at the upper limit is followed by the limit minus 1.
- R10: A change of {speed_sel, fsel, spread_n} sets ofs_word to 0 at the next edge. The sweep then moves downward first, so the first tick after the restart gives -1.
- R11: The rate tick fires on every RATE_DIV-th clock edge counted from reset release, so an active sweep changes value exactly every RATE_DIV cycles (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 1 | Speed select, bit 2 of the select code |
| fsel | input | 2 | Low two bits of the select code |
| spread_n | input | 1 | Spread enable, active low |
| mode_code | output | 3 | Registered select code |
| hiz_flag | output | 1 | Outputs-to-high-impedance mode |
| test_flag | output | 1 | Divided-reference test mode |
| ofs_word | output | OFS_W (8) | Signed offset in units of 0.01% |

## Verification
The mode code and both flags are due one rising edge after the select inputs change. A restart forces the offset to zero at that same edge. Sweep steps appear on the edge that ends each RATE_DIV-cycle tick period. The bench drives inputs on the falling edge and samples outputs on the next falling edge. It checks these against a cycle model that is updated on each rising edge from the stated requirements, so every comparison falls half a cycle after the edge that produced the value. Directed holds record the extremes of the sweep, the value after each reversal, the gap between steps and the first step after a restart. Seeded random segments then mix codes, spread settings and hold lengths.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

   // select code values whose behaviour is fixed
   localparam logic [2:0] CODE_HIZ  = 3'b000;
   localparam logic [2:0] CODE_TEST = 3'b100;

   // spread class carried by the two low select bits
   typedef enum logic [1:0] {
      SPR_NONE    = 2'b00,
      SPR_CENTER  = 2'b01,
      SPR_DEEP    = 2'b10,
      SPR_SHALLOW = 2'b11
   } spread_kind_e;

   // registered configuration seen by the sweep
   typedef struct packed {
      logic [2:0] code;
      logic       hiz;
      logic       test;
      logic       active;
   } mode_cfg_s;

endpackage

// File: rtl/ssc_rate_tick.sv
module ssc_rate_tick #(
   parameter int RATE_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CNT_W = (RATE_DIV > 1) ? $clog2(RATE_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RATE_DIV - 1);

   generate
      if (RATE_DIV < 1) begin : g_bad_rate
         $error("RATE_DIV must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (RATE_DIV > 1) begin : g_gap_chk
         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o); // R11
      end
   endgenerate

endmodule

// File: rtl/ssc_cfg_watch.sv
module ssc_cfg_watch (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] code_i,
   input  logic       spread_n_i,
   output logic       restart_o
);
   logic [3:0] seen_q;

   // restart in the cycle in which the live setting differs from the stored one
   assign restart_o = ({code_i, spread_n_i} != seen_q);

   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= {3'b000, 1'b1};
      else        seen_q <= {code_i, spread_n_i};
   end

endmodule

// File: rtl/ssc_mode_decode.sv
module ssc_mode_decode
   import ssc_pkg::*;
#(
   parameter int OFS_W         = 8,
   parameter int CENTER_DEPTH  = 45,
   parameter int DEEP_DEPTH    = 100,
   parameter int SHALLOW_DEPTH = 50
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2:0]              code_i,
   input  logic                    spread_n_i,
   output mode_cfg_s               cfg_o,
   output logic signed [OFS_W-1:0] lo_o,
   output logic signed [OFS_W-1:0] hi_o
);
   localparam int MAG_MAX = (1 << (OFS_W - 1)) - 1;
   localparam logic signed [OFS_W-1:0] C_LO = OFS_W'(-CENTER_DEPTH);
   localparam logic signed [OFS_W-1:0] C_HI = OFS_W'(CENTER_DEPTH);
   localparam logic signed [OFS_W-1:0] D_LO = OFS_W'(-DEEP_DEPTH);
   localparam logic signed [OFS_W-1:0] S_LO = OFS_W'(-SHALLOW_DEPTH);

   generate
      if (CENTER_DEPTH < 1 || CENTER_DEPTH > MAG_MAX) begin : g_bad_c
         $error("CENTER_DEPTH does not fit OFS_W");
      end
      if (DEEP_DEPTH < 1 || DEEP_DEPTH > MAG_MAX) begin : g_bad_d
         $error("DEEP_DEPTH does not fit OFS_W");
      end
      if (SHALLOW_DEPTH < 1 || SHALLOW_DEPTH > MAG_MAX) begin : g_bad_s
         $error("SHALLOW_DEPTH does not fit OFS_W");
      end
   endgenerate

   spread_kind_e              kind;
   mode_cfg_s                 cfg_d;
   logic signed [OFS_W-1:0]   lo_d, hi_d;

   always_comb begin
      kind         = spread_kind_e'(code_i[1:0]);
      cfg_d.code   = code_i;
      cfg_d.hiz    = (code_i == CODE_HIZ);
      cfg_d.test   = (code_i == CODE_TEST);
      cfg_d.active = (kind != SPR_NONE) && !spread_n_i;
      lo_d = '0;
      hi_d = '0;
      unique case (kind)
         SPR_CENTER:  begin lo_d = C_LO; hi_d = C_HI; end
         SPR_DEEP:    begin lo_d = D_LO; hi_d = '0;   end
         SPR_SHALLOW: begin lo_d = S_LO; hi_d = '0;   end
         default:     begin lo_d = '0;   hi_d = '0;   end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_o <= '{code: CODE_HIZ, hiz: 1'b1, test: 1'b0, active: 1'b0};
         lo_o  <= '0;
         hi_o  <= '0;
      end else begin
         cfg_o <= cfg_d;
         lo_o  <= lo_d;
         hi_o  <= hi_d;
      end
   end

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cfg_o.hiz, cfg_o.test, cfg_o.active}) <= 1); // R2

endmodule

// File: rtl/ssc_tri_sweep.sv
module ssc_tri_sweep #(
   parameter int OFS_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_i,
   input  logic                    restart_i,
   input  logic                    active_i,
   input  logic signed [OFS_W-1:0] lo_i,
   input  logic signed [OFS_W-1:0] hi_i,
   output logic signed [OFS_W-1:0] ofs_o
);
   logic up_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs_o <= '0;
         up_q  <= 1'b0;
      end else if (restart_i || !active_i) begin
         ofs_o <= '0;
         up_q  <= 1'b0;
      end else if (tick_i) begin
         if (up_q) begin
            if (ofs_o >= hi_i) begin
               up_q  <= 1'b0;
               ofs_o <= ofs_o - 1'b1;
            end else begin
               ofs_o <= ofs_o + 1'b1;
            end
         end else begin
            if (ofs_o <= lo_i) begin
               up_q  <= 1'b1;
               ofs_o <= ofs_o + 1'b1;
            end else begin
               ofs_o <= ofs_o - 1'b1;
            end
         end
      end
   end

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_i && active_i && !tick_i) |=> $stable(ofs_o)); // R8
   AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_i && active_i && tick_i) |=> (ofs_o != $past(ofs_o))); // R8
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (ofs_o == '0)); // R10
   AST_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |-> (ofs_o >= lo_i && ofs_o <= hi_i)); // R5

endmodule

// File: rtl/ssc_mode_sweep.sv
module ssc_mode_sweep
   import ssc_pkg::*;
#(
   parameter int OFS_W         = 8,
   parameter int RATE_DIV      = 4,
   parameter int CENTER_DEPTH  = 45,
   parameter int DEEP_DEPTH    = 100,
   parameter int SHALLOW_DEPTH = 50
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    speed_sel,
   input  logic [1:0]              fsel,
   input  logic                    spread_n,
   output logic [2:0]              mode_code,
   output logic                    hiz_flag,
   output logic                    test_flag,
   output logic signed [OFS_W-1:0] ofs_word
);
   logic [2:0]              sel_code;
   logic                    tick;
   logic                    restart;
   mode_cfg_s               cfg;
   logic signed [OFS_W-1:0] lo_b, hi_b;

   assign sel_code = {speed_sel, fsel};

   ssc_rate_tick #(.RATE_DIV(RATE_DIV)) tick_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   ssc_cfg_watch watch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .code_i     (sel_code),
      .spread_n_i (spread_n),
      .restart_o  (restart)
   );

   ssc_mode_decode #(
      .OFS_W         (OFS_W),
      .CENTER_DEPTH  (CENTER_DEPTH),
      .DEEP_DEPTH    (DEEP_DEPTH),
      .SHALLOW_DEPTH (SHALLOW_DEPTH)
   ) decode_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .code_i     (sel_code),
      .spread_n_i (spread_n),
      .cfg_o      (cfg),
      .lo_o       (lo_b),
      .hi_o       (hi_b)
   );

   ssc_tri_sweep #(.OFS_W(OFS_W)) sweep_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .restart_i (restart),
      .active_i  (cfg.active),
      .lo_i      (lo_b),
      .hi_i      (hi_b),
      .ofs_o     (ofs_word)
   );

   assign mode_code = cfg.code;
   assign hiz_flag  = cfg.hiz;
   assign test_flag = cfg.test;

   AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_flag |-> (ofs_word == '0)); // R1
   AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      test_flag |-> (ofs_word == '0)); // R2
   AST_MODE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mode_code == $past(sel_code))); // R3
   AST_SPREAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (spread_n && !restart) |=> (ofs_word == '0)); // R4

endmodule

// File: tb/ssc_mode_sweep_tb.sv
module ssc_mode_sweep_tb_top;
   localparam int RATE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic speed_sel = 1'b0;
   logic [1:0] fsel = 2'b00;
   logic spread_n = 1'b1;
   logic [2:0] mode_code;
   logic hiz_flag, test_flag;
   logic signed [7:0] ofs_word;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit chk_en = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   ssc_mode_sweep #(.RATE_DIV(RATE)) dut_i (
      .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .fsel(fsel),
      .spread_n(spread_n), .mode_code(mode_code), .hiz_flag(hiz_flag),
      .test_flag(test_flag), .ofs_word(ofs_word)
   );

   // expected bounds by requirement R5, R6, R7
   function automatic int lo_of(logic [1:0] f);
      case (f)
         2'b01: return -45;
         2'b10: return -100;
         2'b11: return -50;
         default: return 0;
      endcase
   endfunction
   function automatic int hi_of(logic [1:0] f);
      return (f == 2'b01) ? 45 : 0;
   endfunction

   // cycle model built from the requirements
   int m_cnt = 0;
   logic [3:0] m_cfg = 4'b0001;
   int m_ofs = 0;
   bit m_up = 1'b0;
   logic [2:0] m_mode = 3'b000;
   bit m_hiz = 1'b1, m_test = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_cfg = 4'b0001; m_ofs = 0; m_up = 1'b0;
         m_mode = 3'b000; m_hiz = 1'b1; m_test = 1'b0;
      end else begin
         bit tk, act;
         logic [3:0] cur;
         tk = (m_cnt == RATE - 1);
         m_cnt = tk ? 0 : m_cnt + 1;
         cur = {speed_sel, fsel, spread_n};
         act = (m_cfg[2:1] != 2'b00) && !m_cfg[0];
         if (cur != m_cfg || !act) begin
            m_ofs = 0; m_up = 1'b0;
         end else if (tk) begin
            if (m_up) begin
               if (m_ofs >= hi_of(m_cfg[2:1])) begin m_up = 1'b0; m_ofs--; end
               else m_ofs++;
            end else begin
               if (m_ofs <= lo_of(m_cfg[2:1])) begin m_up = 1'b1; m_ofs++; end
               else m_ofs--;
            end
         end
         m_cfg  = cur;
         m_mode = cur[3:1];
         m_hiz  = (cur[3:1] == 3'b000);
         m_test = (cur[3:1] == 3'b100);
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // every-cycle comparison against the model, half a cycle after the edge
   always @(negedge clk) begin
      cyc++;
      if (chk_en && rst_n) begin
         check(mode_code == m_mode, "R3 mode_code", int'(mode_code), int'(m_mode));
         check(hiz_flag == m_hiz, "R1 hiz_flag", int'(hiz_flag), int'(m_hiz));
         check(test_flag == m_test, "R2 test_flag", int'(test_flag), int'(m_test));
         if (m_cfg[0] || m_cfg[2:1] == 2'b00)
            check(int'(ofs_word) == m_ofs, "R4 idle offset", int'(ofs_word), m_ofs);
         else
            check(int'(ofs_word) == m_ofs, "R8 sweep offset", int'(ofs_word), m_ofs);
      end
   end

   task automatic set_in(logic [2:0] code, logic sp);
      @(negedge clk);
      speed_sel = code[2]; fsel = code[1:0]; spread_n = sp;
   endtask

   // hold a spread mode and check extremes, reversals and step spacing
   task automatic sweep_hold(logic [2:0] code, int n, string req);
      int mn = 0, mx = 0, last_chg = -1, prev = 0;
      bit rev_ok = 1'b1, gap_ok = 1'b1;
      set_in(code, 1'b0);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (int'(ofs_word) != prev) begin
            if (prev == lo_of(code[1:0]) && int'(ofs_word) != prev + 1) rev_ok = 1'b0;
            if (prev == hi_of(code[1:0]) && i > 2 && int'(ofs_word) != prev - 1) rev_ok = 1'b0;
            if (last_chg >= 0 && i - last_chg != RATE) gap_ok = 1'b0;
            last_chg = i;
         end
         prev = int'(ofs_word);
         if (prev < mn) mn = prev;
         if (prev > mx) mx = prev;
      end
      check(mn == lo_of(code[1:0]), {req, " lower limit"}, mn, lo_of(code[1:0]));
      check(mx == hi_of(code[1:0]), {req, " upper limit"}, mx, hi_of(code[1:0]));
      check(rev_ok, "R9 reversal at limit", int'(rev_ok), 1);
      check(gap_ok, "R11 step spacing", int'(gap_ok), 1);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_up();
   end

   initial begin
      void'($urandom(32'd20241));
      repeat (3) @(negedge clk);
      // reset state: R1 hiz, R3 mode 000, zero offset
      check(hiz_flag == 1'b1, "R1 reset hiz", int'(hiz_flag), 1);
      check(mode_code == 3'b000, "R3 reset mode", int'(mode_code), 0);
      check(ofs_word == 0, "R4 reset offset", int'(ofs_word), 0);
      rst_n = 1'b1;
      chk_en = 1'b1;

      // R1 and R2: spread enabled but ignored
      set_in(3'b000, 1'b0);
      repeat (20) @(negedge clk);
      check(hiz_flag && ofs_word == 0, "R1 hiz ignores spread", int'(ofs_word), 0);
      set_in(3'b100, 1'b0);
      repeat (20) @(negedge clk);
      check(test_flag && !hiz_flag && ofs_word == 0, "R2 test ignores spread",
            int'(ofs_word), 0);

      // R4: spread disabled in a spread-capable code
      set_in(3'b110, 1'b1);
      repeat (40) @(negedge clk);
      check(ofs_word == 0, "R4 spread off", int'(ofs_word), 0);

      // R5, R6, R7 with 66.6 and 100 MHz codes
      sweep_hold(3'b001, 800, "R5 center");
      sweep_hold(3'b110, 900, "R6 deep down");
      sweep_hold(3'b011, 500, "R7 shallow down");
      sweep_hold(3'b101, 600, "R5 center 100MHz");

      // R10: restart from mid-sweep
      begin
         int wait_n = 0;
         set_in(3'b010, 1'b0);
         @(negedge clk);
         check(ofs_word == 0, "R10 zero after change", int'(ofs_word), 0);
         while (ofs_word == 0 && wait_n < 2 * RATE) begin
            @(negedge clk); wait_n++;
         end
         check(ofs_word == -1, "R10 first step down", int'(ofs_word), -1);
         check(wait_n <= RATE, "R11 first tick within period", wait_n, RATE);
      end

      // seeded random segments
      for (int s = 0; s < 60; s++) begin
         logic [2:0] c;
         c = 3'($urandom_range(0, 7));
         set_in(c, 1'($urandom_range(0, 3) == 0));
         repeat ($urandom_range(1, 300)) @(negedge clk);
      end
      repeat (2) @(negedge clk);
      finish_up();
   end
endmodule